// File: doc/BRIEF.md
# Byte-to-Word Width Adapter for a Parallel USB Transceiver Bus

This block connects a link-layer engine that moves one byte per clock to the parallel data bus of a USB transceiver. That bus runs either 8 bits wide or 16 bits wide. On the transmit side, bytes from the link are held in a staging register and offered to the transceiver with a transmit-valid flag. The word stays on the bus until the transceiver acknowledges it with its ready input. In 16-bit mode, two bytes are packed into one word, with the first byte in the low half. A packet with an odd number of bytes ends with a word that carries one byte, marked by a low high-half-valid flag.

On the receive side, every word that the transceiver flags as valid is split into bytes. The bytes enter a small buffer and go to the link one per clock, low half first. Bus direction is modelled with separate data-out, data-in and per-lane drive-enable signals. The high-half-valid flag is handled the same way.

The width select is sampled only while both directions are quiet. A change in the middle of a packet therefore waits until the packet is over.

Top module: `utmi_width_adapter`

## Requirements
- R1: In narrow mode (width state 0), each link byte appears on `bus_o[7:0]` with `bus_o[15:8]` zero, `bus_oe_o` = 2'b01, and `hv_oe_o` low.
- R2: In wide mode (width state 1), two consecutive link bytes form one word: the first byte goes to `bus_o[7:0]` and the second to `bus_o[15:8]`. The word has `hv_o` = 1, `bus_oe_o` = 2'b11 and `hv_oe_o` = 1.
- R3: In wide mode, a packet whose last byte (`lk_tx_last_i` = 1) falls on an even position (zero-based) ends with a word holding that byte in `bus_o[7:0]`. That word has `bus_o[15:8]` = 0 and `hv_o` = 0.
- R4: While `phy_txvalid_o` is high and `phy_txready_i` is low, the word and `hv_o` stay unchanged and `lk_tx_ready_o` is low. A word is taken only on a clock with `phy_txready_i` high. A high `phy_txready_i` while no word is held has no effect.
- R5: While `phy_txvalid_o` is low, `bus_oe_o` is 2'b00 and `hv_oe_o` is 0.
- R6: In narrow mode, each clock with `phy_rxvalid_i` high delivers exactly one byte, `bus_i[15:8]`, to the link. `bus_i[7:0]` and `hv_i` have no effect.
- R7: In wide mode, a received word with `hv_i` = 1 delivers `bus_i[7:0]` and then `bus_i[15:8]` on consecutive link cycles.
- R8: In wide mode, a received word with `hv_i` = 0 delivers only `bus_i[7:0]`.
- R9: Received bytes reach the link in arrival order, one per clock, starting the clock after capture. Back-to-back wide words are absorbed by an `RX_DEPTH`-byte buffer without loss.
- R10: `wide_sel_i` takes effect only on a clock where no transmit byte is held or offered and `phy_rxvalid_i` is low. A change during a packet is ignored until the packet is over.
- R11: After reset, `phy_txvalid_o`, `lk_rx_valid_o`, `bus_oe_o` and `hv_oe_o` are low and `lk_tx_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_sel_i | input | 1 | Width select: 0 narrow (8-bit), 1 wide (16-bit) |
| lk_tx_valid_i | input | 1 | Link offers a transmit byte |
| lk_tx_data_i | input | 8 | Transmit byte |
| lk_tx_last_i | input | 1 | Offered byte is the last byte of the packet |
| lk_tx_ready_o | output | 1 | Adapter accepts the offered byte this clock |
| lk_rx_valid_o | output | 1 | Received byte valid (consumed every cycle it is high) |
| lk_rx_data_o | output | 8 | Received byte |
| phy_txvalid_o | output | 1 | Transmit word valid towards the transceiver |
| phy_txready_i | input | 1 | Transceiver took the word on this edge |
| phy_rxvalid_i | input | 1 | Transceiver presents a received word or byte |
| bus_i | input | 16 | Data bus as seen at the pins |
| bus_o | output | 16 | Data driven onto the bus |
| bus_oe_o | output | 2 | Per-byte-lane drive enable |
| hv_i | input | 1 | High-half-valid flag from the transceiver |
| hv_o | output | 1 | High-half-valid flag driven by the adapter |
| hv_oe_o | output | 1 | Drive enable for the high-half-valid flag |

## Verification
The bench builds the adapter with its default four-byte receive buffer. With that size, a pair of back-to-back wide words raises the buffer to three bytes. This exercises the two-in/one-out path and the pointer wrap without ever overflowing. The transceiver model varies its ready pattern, from always ready to long stalls, so that the hold and back-pressure paths are hit in both widths. The bench also flips the width select mid-packet in both directions.

// File: rtl/utmi_wa_pkg.sv
`timescale 1ns/1ps
package utmi_wa_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned WORD_W = BYTE_W * LANES;
  localparam int unsigned CNT_W  = $clog2(LANES + 1);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef enum logic {
    WIDTH_8  = 1'b0,
    WIDTH_16 = 1'b1
  } width_e;
endpackage

// File: rtl/utmi_wa_tx_pack.sv
`timescale 1ns/1ps
module utmi_wa_tx_pack
  import utmi_wa_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  width_e width_i,
  input  logic   in_valid_i,
  input  byte_t  in_data_i,
  input  logic   in_last_i,
  output logic   in_ready_o,
  output logic   out_valid_o,
  output word_t  out_data_o,
  output logic   out_full_o,
  input  logic   out_ready_i,
  output logic   empty_o
);
  byte_t lane_q [LANES];
  byte_t lane_d [LANES];
  cnt_t  cnt_q, cnt_d, cnt_base;
  logic  done_q, done_d, done_base;
  logic  consume, accept;

  assign consume    = done_q & out_ready_i;
  assign in_ready_o = ~done_q | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_comb begin
    cnt_base  = consume ? '0 : cnt_q;
    done_base = consume ? 1'b0 : done_q;
    cnt_d     = cnt_base;
    done_d    = done_base;
    for (int i = 0; i < LANES; i++) lane_d[i] = lane_q[i];
    if (accept) begin
      for (int i = 0; i < LANES; i++) begin
        if (cnt_base == cnt_t'(i)) lane_d[i] = in_data_i;
      end
      cnt_d  = cnt_base + cnt_t'(1);
      // word closes on narrow width, packet end, or top lane filled
      done_d = (width_i == WIDTH_8) | in_last_i | (cnt_base == cnt_t'(LANES - 1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      for (int i = 0; i < LANES; i++) lane_q[i] <= '0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      for (int i = 0; i < LANES; i++) lane_q[i] <= lane_d[i];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_out
    assign out_data_o[g*BYTE_W +: BYTE_W] = (cnt_q > cnt_t'(g)) ? lane_q[g] : '0;
  end

  assign out_valid_o = done_q;
  assign out_full_o  = done_q & (cnt_q == cnt_t'(LANES));
  assign empty_o     = (cnt_q == '0);
endmodule

// File: rtl/utmi_wa_rx_split.sv
`timescale 1ns/1ps
module utmi_wa_rx_split
  import utmi_wa_pkg::*;
(
  input  width_e width_i,
  input  logic   valid_i,
  input  word_t  bus_i,
  input  logic   hv_i,
  output cnt_t   push_cnt_o,
  output word_t  push_data_o
);
  always_comb begin
    push_cnt_o  = '0;
    push_data_o = '0;
    if (width_i == WIDTH_8) begin
      // narrow receive lane is the top byte of the bus
      push_data_o[BYTE_W-1:0] = bus_i[WORD_W-1 -: BYTE_W];
      if (valid_i) push_cnt_o = cnt_t'(1);
    end else begin
      push_data_o = bus_i;
      if (valid_i) push_cnt_o = hv_i ? cnt_t'(LANES) : cnt_t'(1);
    end
  end
endmodule

// File: rtl/utmi_wa_byte_fifo.sv
`timescale 1ns/1ps
module utmi_wa_byte_fifo
  import utmi_wa_pkg::*;
#(
  parameter int unsigned DEPTH = 4  // power of two
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  cnt_t                     push_cnt_i,
  input  word_t                    push_data_i,
  input  logic                     pop_i,
  output logic                     valid_o,
  output byte_t                    data_o,
  output logic [$clog2(DEPTH):0]   level_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned LVL_W = PTR_W + 1;

  byte_t            mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [LVL_W-1:0] level_q;

  always_ff @(posedge clk_i) begin
    for (int l = 0; l < LANES; l++) begin
      if (push_cnt_i > cnt_t'(l))
        mem_q[wr_q + PTR_W'(l)] <= push_data_i[l*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else begin
      wr_q    <= wr_q + PTR_W'(push_cnt_i);
      rd_q    <= rd_q + PTR_W'(pop_i);
      level_q <= level_q + LVL_W'(push_cnt_i) - LVL_W'(pop_i);
    end
  end

  assign valid_o = (level_q != '0);
  assign data_o  = mem_q[rd_q];
  assign level_o = level_q;
endmodule

// File: rtl/utmi_width_adapter.sv
`timescale 1ns/1ps
module utmi_width_adapter
  import utmi_wa_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_sel_i,
  input  logic              lk_tx_valid_i,
  input  logic [BYTE_W-1:0] lk_tx_data_i,
  input  logic              lk_tx_last_i,
  output logic              lk_tx_ready_o,
  output logic              lk_rx_valid_o,
  output logic [BYTE_W-1:0] lk_rx_data_o,
  output logic              phy_txvalid_o,
  input  logic              phy_txready_i,
  input  logic              phy_rxvalid_i,
  input  logic [WORD_W-1:0] bus_i,
  output logic [WORD_W-1:0] bus_o,
  output logic [LANES-1:0]  bus_oe_o,
  input  logic              hv_i,
  output logic              hv_o,
  output logic              hv_oe_o
);
  localparam int unsigned LVL_W = $clog2(RX_DEPTH) + 1;

  width_e           mode_q;
  logic             tx_empty, tx_valid, tx_full;
  word_t            tx_word;
  logic             idle;
  cnt_t             rx_push_cnt;
  word_t            rx_push_data;
  logic [LVL_W-1:0] rx_level;

  // width follows the select only between packets
  assign idle = tx_empty & ~tx_valid & ~lk_tx_valid_i & ~phy_rxvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_q <= WIDTH_8;
    else if (idle) mode_q <= width_e'(wide_sel_i);
  end

  utmi_wa_tx_pack u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .width_i     (mode_q),
    .in_valid_i  (lk_tx_valid_i),
    .in_data_i   (lk_tx_data_i),
    .in_last_i   (lk_tx_last_i),
    .in_ready_o  (lk_tx_ready_o),
    .out_valid_o (tx_valid),
    .out_data_o  (tx_word),
    .out_full_o  (tx_full),
    .out_ready_i (phy_txready_i),
    .empty_o     (tx_empty)
  );

  assign phy_txvalid_o = tx_valid;
  assign bus_o         = tx_word;
  assign hv_o          = tx_full;
  assign hv_oe_o       = tx_valid & (mode_q == WIDTH_16);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_oe
    if (g == 0) begin : g_base
      assign bus_oe_o[g] = tx_valid;
    end else begin : g_upper
      assign bus_oe_o[g] = tx_valid & (mode_q == WIDTH_16);
    end
  end

  utmi_wa_rx_split u_rx_split (
    .width_i     (mode_q),
    .valid_i     (phy_rxvalid_i),
    .bus_i       (bus_i),
    .hv_i        (hv_i),
    .push_cnt_o  (rx_push_cnt),
    .push_data_o (rx_push_data)
  );

  utmi_wa_byte_fifo #(.DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_cnt_i  (rx_push_cnt),
    .push_data_i (rx_push_data),
    .pop_i       (lk_rx_valid_o),
    .valid_o     (lk_rx_valid_o),
    .data_o      (lk_rx_data_o),
    .level_o     (rx_level)
  );
endmodule

// File: rtl/utmi_width_adapter_chk.sv
`timescale 1ns/1ps
module utmi_width_adapter_chk #(
  parameter int unsigned RX_DEPTH = 4
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         mode_q,
  input logic                         phy_txvalid_o,
  input logic                         phy_txready_i,
  input logic                         phy_rxvalid_i,
  input logic [15:0]                  bus_o,
  input logic [1:0]                   bus_oe_o,
  input logic                         hv_o,
  input logic                         hv_oe_o,
  input logic                         lk_tx_ready_o,
  input logic [$clog2(RX_DEPTH):0]    rx_level
);
  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phy_txvalid_o |-> (bus_oe_o == 2'b00) && !hv_oe_o);

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_txvalid_o && !phy_txready_i |=> phy_txvalid_o && $stable(bus_o) && $stable(hv_o));

  assert_backpressure_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_tx_ready_o |-> phy_txvalid_o && !phy_txready_i);

  assert_full_word_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_txvalid_o && hv_o |-> (bus_oe_o == 2'b11) && hv_oe_o);

  assert_odd_tail_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_txvalid_o && mode_q && !hv_o |-> bus_o[15:8] == 8'h00);

  assert_narrow_lane_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_txvalid_o && !mode_q |-> !hv_o && (bus_o[15:8] == 8'h00));

  assert_mode_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_rxvalid_i |=> $stable(mode_q));

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_level <= ($clog2(RX_DEPTH) + 1)'(RX_DEPTH));
endmodule

bind utmi_width_adapter utmi_width_adapter_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mode_q        (mode_q),
  .phy_txvalid_o (phy_txvalid_o),
  .phy_txready_i (phy_txready_i),
  .phy_rxvalid_i (phy_rxvalid_i),
  .bus_o         (bus_o),
  .bus_oe_o      (bus_oe_o),
  .hv_o          (hv_o),
  .hv_oe_o       (hv_oe_o),
  .lk_tx_ready_o (lk_tx_ready_o),
  .rx_level      (rx_level)
);

// File: tb/utmi_width_adapter_tb.sv
`timescale 1ns/1ps
module utmi_width_adapter_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide_sel_i = 1'b0;
  logic        lk_tx_valid_i = 1'b0;
  logic [7:0]  lk_tx_data_i = '0;
  logic        lk_tx_last_i = 1'b0;
  logic        lk_tx_ready_o;
  logic        lk_rx_valid_o;
  logic [7:0]  lk_rx_data_o;
  logic        phy_txvalid_o;
  logic        phy_txready_i = 1'b1;
  logic        phy_rxvalid_i = 1'b0;
  logic [15:0] bus_i = '0;
  logic [15:0] bus_o;
  logic [1:0]  bus_oe_o;
  logic        hv_i = 1'b0;
  logic        hv_o;
  logic        hv_oe_o;

  int checks = 0;
  int fails  = 0;
  int ready_pat = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [19:0] exp_tx[$];
  string       exp_tx_tag[$];
  logic [7:0]  exp_rx[$];
  string       exp_rx_tag[$];

  always #10 clk = ~clk;

  utmi_width_adapter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wide_sel_i(wide_sel_i),
    .lk_tx_valid_i(lk_tx_valid_i), .lk_tx_data_i(lk_tx_data_i),
    .lk_tx_last_i(lk_tx_last_i), .lk_tx_ready_o(lk_tx_ready_o),
    .lk_rx_valid_o(lk_rx_valid_o), .lk_rx_data_o(lk_rx_data_o),
    .phy_txvalid_o(phy_txvalid_o), .phy_txready_i(phy_txready_i),
    .phy_rxvalid_i(phy_rxvalid_i), .bus_i(bus_i), .bus_o(bus_o),
    .bus_oe_o(bus_oe_o), .hv_i(hv_i), .hv_o(hv_o), .hv_oe_o(hv_oe_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // transceiver ready pattern
  always @(negedge clk) begin
    cyc++;
    case (ready_pat)
      0: phy_txready_i = 1'b1;
      1: phy_txready_i = cyc[0];
      default: phy_txready_i = (cyc % 4 == 3);
    endcase
  end

  // monitor: samples 2 ns before each rising edge
  always begin
    @(negedge clk);
    #8;
    if (rst_ni) begin
      if (phy_txvalid_o && phy_txready_i) begin
        if (exp_tx.size() == 0) check(1'b0, "R4 unexpected word", {12'h0, bus_o}, 32'h0);
        else begin
          logic [19:0] e;
          string t;
          e = exp_tx.pop_front();
          t = exp_tx_tag.pop_front();
          check({bus_oe_o, hv_oe_o, hv_o, bus_o} == e, t, {bus_oe_o, hv_oe_o, hv_o, bus_o}, e);
        end
      end
      if (phy_txvalid_o && !phy_txready_i)
        check(lk_tx_ready_o == 1'b0, "R4 stall backpressure", lk_tx_ready_o, 0);
      if (!phy_txvalid_o)
        check(bus_oe_o == 2'b00 && !hv_oe_o, "R5 released bus", {bus_oe_o, hv_oe_o}, 0);
      if (lk_rx_valid_o) begin
        if (exp_rx.size() == 0) check(1'b0, "R6 unexpected rx byte", lk_rx_data_o, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_rx.pop_front();
          t = exp_rx_tag.pop_front();
          check(lk_rx_data_o == e, t, lk_rx_data_o, e);
        end
      end
    end
  end

  // driver: push expected words, then offer bytes on the link
  task automatic send_tx(input int n, input logic [7:0] seed, input bit wide, input int flip_at, input string tag);
    logic [7:0] b[$];
    for (int i = 0; i < n; i++) b.push_back(seed + 8'(i * 17));
    if (!wide) begin
      for (int i = 0; i < n; i++) begin
        exp_tx.push_back({2'b01, 1'b0, 1'b0, 8'h00, b[i]});
        exp_tx_tag.push_back({tag, " narrow byte"});
      end
    end else begin
      for (int i = 0; i < n; i += 2) begin
        if (i + 1 < n) begin
          exp_tx.push_back({2'b11, 1'b1, 1'b1, b[i+1], b[i]});
          exp_tx_tag.push_back({tag, " packed pair"});
        end else begin
          exp_tx.push_back({2'b11, 1'b1, 1'b0, 8'h00, b[i]});
          exp_tx_tag.push_back({tag, " odd tail"});
        end
      end
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lk_tx_valid_i = 1'b1;
      lk_tx_data_i  = b[i];
      lk_tx_last_i  = (i == n - 1);
      if (i == flip_at) wide_sel_i = ~wide_sel_i;
      #8;
      while (!lk_tx_ready_o) begin
        @(negedge clk);
        #8;
      end
    end
    @(negedge clk);
    lk_tx_valid_i = 1'b0;
    lk_tx_last_i  = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_tx.size() != 0 || exp_rx.size() != 0) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic rx_word(input logic [15:0] w, input bit hv, input bit wide, input string tag);
    @(negedge clk);
    phy_rxvalid_i = 1'b1;
    bus_i = w;
    hv_i  = hv;
    if (!wide) begin
      exp_rx.push_back(w[15:8]); exp_rx_tag.push_back(tag);
    end else begin
      exp_rx.push_back(w[7:0]); exp_rx_tag.push_back(tag);
      if (hv) begin
        exp_rx.push_back(w[15:8]); exp_rx_tag.push_back(tag);
      end
    end
  endtask

  task automatic rx_idle();
    @(negedge clk);
    phy_rxvalid_i = 1'b0;
    bus_i = '0;
    hv_i  = 1'b0;
  endtask

  task automatic set_mode(input bit w);
    @(negedge clk);
    wide_sel_i = w;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset values
    check(phy_txvalid_o == 1'b0, "R11 txvalid in reset", phy_txvalid_o, 0);
    check(lk_rx_valid_o == 1'b0, "R11 rx valid in reset", lk_rx_valid_o, 0);
    check(bus_oe_o == 2'b00 && hv_oe_o == 1'b0, "R11 drive enables in reset", {bus_oe_o, hv_oe_o}, 0);
    check(lk_tx_ready_o == 1'b1, "R11 link ready in reset", lk_tx_ready_o, 1);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // narrow transmit, always ready (R1, R4 idle ready no effect)
    send_tx(5, 8'h10, 1'b0, -1, "R1");
    drain();
    ready_pat = 2;
    send_tx(4, 8'h33, 1'b0, -1, "R4 R1 stalled");
    drain();

    // wide transmit: even, odd, stalled
    set_mode(1'b1);
    ready_pat = 0;
    send_tx(6, 8'h41, 1'b1, -1, "R2");
    drain();
    send_tx(5, 8'h52, 1'b1, -1, "R3");
    drain();
    send_tx(1, 8'hE7, 1'b1, -1, "R3 single byte");
    drain();
    ready_pat = 1;
    send_tx(7, 8'h05, 1'b1, -1, "R4 R2 alternating");
    drain();
    ready_pat = 2;
    send_tx(4, 8'h90, 1'b1, -1, "R4 R2 stalled");
    drain();
    ready_pat = 0;

    // R10: flip to narrow mid-packet, packet stays wide
    send_tx(4, 8'hA0, 1'b1, 1, "R10 flip ignored");
    drain();
    // flip now in effect: narrow
    send_tx(3, 8'hC1, 1'b0, -1, "R10 flip adopted R1");
    drain();

    // narrow receive, hv and low lane ignored
    rx_word(16'h5AA5, 1'b1, 1'b0, "R6");
    rx_idle();
    rx_word(16'h3C77, 1'b0, 1'b0, "R6");
    rx_word(16'h12FF, 1'b1, 1'b0, "R6 back-to-back");
    rx_idle();
    drain();

    // wide receive
    set_mode(1'b1);
    rx_word(16'hBEEF, 1'b1, 1'b1, "R7");
    rx_idle();
    rx_idle();
    rx_word(16'hDD42, 1'b0, 1'b1, "R8");
    rx_idle();
    drain();

    // R9 burst with R10 flip during active receive
    @(negedge clk);
    rx_word(16'h2211, 1'b1, 1'b1, "R9 burst");
    wide_sel_i = 1'b0;
    rx_word(16'h4433, 1'b1, 1'b1, "R10 R9 burst flip ignored");
    rx_word(16'h0055, 1'b0, 1'b1, "R9 burst odd");
    rx_idle();
    drain();
    // now narrow
    rx_word(16'h6600, 1'b1, 1'b0, "R10 rx flip adopted R6");
    rx_idle();
    drain();

    check(exp_tx.size() == 0, "R2 all tx words seen", exp_tx.size(), 0);
    check(exp_rx.size() == 0, "R9 all rx bytes seen", exp_rx.size(), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule